// File: doc/BRIEF.md
# Overlapped-translation direct-mapped data cache

This block is a small direct-mapped data cache that sits between a load/store unit and the next memory level. The set is chosen from the page-offset part of the virtual address, so the lookup does not have to wait for address translation. A TLB outside the block turns the page number into a physical page number during the same cycle. The line's stored tag is the physical page number, and the block compares it with the translated value. A line is used only when it is valid, its tag matches, and the TLB reports a hit. If the TLB misses, the access stalls. If the cache misses but the TLB hits, one line is fetched at the physical address, installed, and the access is replayed as a hit.

Stores are write-through with no allocation. A store hit rewrites the line. Every store, hit or miss, sends one write to memory at the full physical address. The block holds one access at a time.

The request, response and memory-request channels are valid/ready. The rules for back-pressure are:
- A request is taken on a cycle where `req_valid` and `req_ready` are both high.
- `req_ready` stays low from that cycle until the response has been taken.
- `rsp_valid`, and the data with it, holds until `rsp_ready`.
- `mem_req_valid`, with its address, direction and data, holds until `mem_req_ready`.

The refill channel `mem_rsp_valid` is a plain one-cycle strobe with no back-pressure. The TLB inputs `tlb_hit` and `tlb_ppn` are sampled in the cycle after a request is taken, and again in each stalled cycle after it. An elaboration check rejects any parameter set where the index and line-offset bits do not fit inside the page offset.

Top module: `vipt_cache`

## Requirements
- R1: Reset and a one-cycle pulse on `flush_all` while idle both clear every valid bit, so the next load to any set misses. Out of reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: The set is selected by virtual address bits [11:2], which lie inside the 12-bit page offset. Two virtual addresses with different page numbers but the same offset, translated to the same physical page, hit the same line.
- R3: The hit test compares the stored tag with `tlb_ppn`. A load to a set holding a line from a different physical page misses and fetches.
- R4: On a load hit with the TLB hit, the block makes no memory request. It returns the line word on `rsp_rdata`, with `rsp_valid` first high one cycle after the request is taken, plus one cycle for each TLB-stall cycle.
- R5: On a load miss with a TLB hit, the block makes exactly one request with `mem_req_write`=0 and `mem_req_paddr` = {ppn, vaddr[11:2], 2'b00}.
- R6: The refill word is written into the line, with its valid bit set and tag = ppn. The access is then replayed as a hit, and the response carries the refill word. `rsp_valid` rises two cycles after the refill strobe, and no second fetch is made. A following load to the same line hits.
- R7: Every store makes exactly one request with `mem_req_write`=1, `mem_req_paddr` = {ppn, vaddr[11:0]} and `mem_req_wdata` = the store data, and makes no fetch. A store hit updates the line, so a following load hits and returns the new word. A store miss leaves the cache unchanged, so a following load misses.
- R8: While `tlb_hit` is low during lookup, the block makes no memory request and gives no response. The access resumes when `tlb_hit` goes high.
- R9: A stalled `mem_req_*` or response holds its valid and payload stable until it is accepted. `req_ready` stays low while an access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_all | input | 1 | Clear all valid bits |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_vaddr | input | VA_BITS (32) | Virtual byte address |
| req_wdata | input | 8*LINE_BYTES (32) | Store data |
| tlb_hit | input | 1 | Translation available |
| tlb_ppn | input | PA_BITS-PAGE_BITS (20) | Translated physical page number |
| rsp_valid | output | 1 | Access complete |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 8*LINE_BYTES (32) | Load data (undefined for stores) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = write-through, 0 = line fetch |
| mem_req_paddr | output | PA_BITS (32) | Physical address |
| mem_req_wdata | output | 8*LINE_BYTES (32) | Write data |
| mem_rsp_valid | input | 1 | Refill word strobe |
| mem_rsp_rdata | input | 8*LINE_BYTES (32) | Refill word |

## Verification
The bench builds the block with its defaults: 1024 lines of 4 bytes and 4 KB pages, so index plus offset fill the page offset exactly. This brings page-number aliasing and page-number tag conflicts within reach, since every bit above the offset comes only from translation. Random stimulus draws indexes from a few low and top sets and physical pages from a pool of four. This produces frequent hits, evictions and store-hit/store-miss pairs. TLB stalls and memory and response back-pressure are varied per access.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_WR_REQ,
    ST_RESP
  } vipt_state_e;
endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
  parameter int IDX_W = 10,
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n || clr_all) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store #(
  parameter int IDX_W  = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int LINES = 1 << IDX_W;

  logic [DATA_W-1:0] line_q [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) line_q[wr_idx] <= wr_data;
  end

  assign rd_data = line_q[rd_idx];
endmodule

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
  import vipt_pkg::*;
#(
  parameter int PAGE_BITS = 12,
  parameter int OFF_W     = 2,
  parameter int IDX_W     = 10,
  parameter int PPN_W     = 20,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [PAGE_BITS-1:0] req_pgoff,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic                 tlb_hit,
  input  logic [PPN_W-1:0]     tlb_ppn,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic                 mem_req_write,
  output logic [PPN_W+PAGE_BITS-1:0] mem_req_paddr,
  output logic [DATA_W-1:0]    mem_req_wdata,
  input  logic                 mem_rsp_valid,
  input  logic [DATA_W-1:0]    mem_rsp_rdata,
  output logic [IDX_W-1:0]     arr_idx,
  input  logic                 arr_valid,
  input  logic [PPN_W-1:0]     arr_tag,
  input  logic [DATA_W-1:0]    arr_data,
  output logic                 tag_we,
  output logic                 dat_we,
  output logic [DATA_W-1:0]    dat_wdata,
  output logic                 stall_w,
  output logic                 fill_we,
  output logic                 st_go
);
  vipt_state_e           state_q;
  logic                  wr_q;
  logic                  replay_q;
  logic [PAGE_BITS-1:0]  pgoff_q;
  logic [DATA_W-1:0]     wdata_q;
  logic [PPN_W-1:0]      ppn_q;
  logic [DATA_W-1:0]     rdata_q;

  logic                  xl_ok;
  logic [PPN_W-1:0]      xl_ppn;
  logic                  line_hit;
  logic                  in_lookup;

  assign arr_idx   = pgoff_q[OFF_W +: IDX_W];
  assign in_lookup = (state_q == ST_LOOKUP);
  // A replayed access reuses the page number captured before the refill.
  assign xl_ok     = replay_q | tlb_hit;
  assign xl_ppn    = replay_q ? ppn_q : tlb_ppn;
  assign line_hit  = arr_valid && (arr_tag == xl_ppn);

  assign stall_w = in_lookup && !xl_ok;
  assign st_go   = in_lookup && xl_ok && wr_q;
  assign fill_we = (state_q == ST_FILL_WAIT) && mem_rsp_valid;

  assign tag_we    = fill_we;
  assign dat_we    = fill_we || (st_go && line_hit);
  assign dat_wdata = fill_we ? mem_rsp_rdata : wdata_q;

  assign req_ready     = (state_q == ST_IDLE);
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_rdata     = rdata_q;
  assign mem_req_valid = (state_q == ST_FILL_REQ) || (state_q == ST_WR_REQ);
  assign mem_req_write = (state_q == ST_WR_REQ);
  assign mem_req_wdata = wdata_q;

  always_comb begin
    if (state_q == ST_WR_REQ) mem_req_paddr = {ppn_q, pgoff_q};
    else mem_req_paddr = {ppn_q, pgoff_q[PAGE_BITS-1:OFF_W], {OFF_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      wr_q     <= 1'b0;
      replay_q <= 1'b0;
      pgoff_q  <= '0;
      wdata_q  <= '0;
      ppn_q    <= '0;
      rdata_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          wr_q     <= req_write;
          pgoff_q  <= req_pgoff;
          wdata_q  <= req_wdata;
          replay_q <= 1'b0;
          state_q  <= ST_LOOKUP;
        end
        ST_LOOKUP: if (xl_ok) begin
          ppn_q    <= xl_ppn;
          replay_q <= 1'b0;
          if (wr_q) state_q <= ST_WR_REQ;
          else if (line_hit) begin
            rdata_q <= arr_data;
            state_q <= ST_RESP;
          end else state_q <= ST_FILL_REQ;
        end
        ST_FILL_REQ: if (mem_req_ready) state_q <= ST_FILL_WAIT;
        ST_FILL_WAIT: if (mem_rsp_valid) begin
          replay_q <= 1'b1;
          state_q  <= ST_LOOKUP;
        end
        ST_WR_REQ: if (mem_req_ready) state_q <= ST_RESP;
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache #(
  parameter int LINE_BYTES = 4,
  parameter int NUM_LINES  = 1024,
  parameter int PAGE_BITS  = 12,
  parameter int PA_BITS    = 32,
  parameter int VA_BITS    = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            flush_all,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic                            req_write,
  input  logic [VA_BITS-1:0]              req_vaddr,
  input  logic [8*LINE_BYTES-1:0]         req_wdata,
  input  logic                            tlb_hit,
  input  logic [PA_BITS-PAGE_BITS-1:0]    tlb_ppn,
  output logic                            rsp_valid,
  input  logic                            rsp_ready,
  output logic [8*LINE_BYTES-1:0]         rsp_rdata,
  output logic                            mem_req_valid,
  input  logic                            mem_req_ready,
  output logic                            mem_req_write,
  output logic [PA_BITS-1:0]              mem_req_paddr,
  output logic [8*LINE_BYTES-1:0]         mem_req_wdata,
  input  logic                            mem_rsp_valid,
  input  logic [8*LINE_BYTES-1:0]         mem_rsp_rdata
);
  localparam int DATA_W = 8 * LINE_BYTES;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int PPN_W  = PA_BITS - PAGE_BITS;

  generate
    if (IDX_W + OFF_W > PAGE_BITS) begin : g_bad_geometry
      $error("cache index and line offset must fit inside the page offset");
    end
  endgenerate

  logic              vpn_unused;
  logic [IDX_W-1:0]  arr_idx;
  logic              arr_valid;
  logic [PPN_W-1:0]  arr_tag;
  logic [DATA_W-1:0] arr_data;
  logic              tag_we;
  logic              dat_we;
  logic [DATA_W-1:0] dat_wdata;
  logic              stall_w;
  logic              fill_we;
  logic              st_go;

  // Only the page offset enters the cache; the page number goes to the TLB.
  assign vpn_unused = ^req_vaddr[VA_BITS-1:PAGE_BITS];

  vipt_ctrl #(
    .PAGE_BITS(PAGE_BITS), .OFF_W(OFF_W), .IDX_W(IDX_W),
    .PPN_W(PPN_W), .DATA_W(DATA_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_pgoff(req_vaddr[PAGE_BITS-1:0]), .req_wdata(req_wdata),
    .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_paddr(mem_req_paddr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .arr_idx(arr_idx), .arr_valid(arr_valid), .arr_tag(arr_tag),
    .arr_data(arr_data), .tag_we(tag_we), .dat_we(dat_we),
    .dat_wdata(dat_wdata), .stall_w(stall_w), .fill_we(fill_we),
    .st_go(st_go)
  );

  vipt_tag_store #(.IDX_W(IDX_W), .TAG_W(PPN_W)) tags_i (
    .clk(clk), .rst_n(rst_n), .clr_all(flush_all),
    .rd_idx(arr_idx), .rd_valid(arr_valid), .rd_tag(arr_tag),
    .wr_en(tag_we), .wr_idx(arr_idx), .wr_tag(mem_req_paddr[PA_BITS-1:PAGE_BITS])
  );

  vipt_data_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) data_i (
    .clk(clk), .rd_idx(arr_idx), .rd_data(arr_data),
    .wr_en(dat_we), .wr_idx(arr_idx), .wr_data(dat_wdata)
  );
endmodule

// File: rtl/vipt_cache_chk.sv
module vipt_cache_chk #(
  parameter int PA_BITS = 32,
  parameter int DATA_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush_all,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [PA_BITS-1:0] mem_req_paddr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic              stall_w,
  input logic              fill_we,
  input logic              st_go
);
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_paddr)
      && $stable(mem_req_write) && $stable(mem_req_wdata)); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R9
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R9
  AST_TLB_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    stall_w |=> !rsp_valid && !mem_req_valid); // R8
  AST_FILL_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we && !flush_all |-> ##2 rsp_valid); // R6
  AST_STORE_WT: assert property (@(posedge clk) disable iff (!rst_n)
    st_go |=> mem_req_valid && mem_req_write); // R7
endmodule

bind vipt_cache vipt_cache_chk #(.PA_BITS(PA_BITS), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
  .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_paddr(mem_req_paddr),
  .mem_req_wdata(mem_req_wdata),
  .stall_w(stall_w), .fill_we(fill_we), .st_go(st_go)
);

// File: tb/vipt_cache_tb_top.sv
`timescale 1ns/1ps
module vipt_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_all = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [31:0] req_wdata = '0;
  logic        tlb_hit = 1'b0;
  logic [19:0] tlb_ppn = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_rdata;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_write;
  logic [31:0] mem_req_paddr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;

  always #5 clk = ~clk;

  vipt_cache dut_i (
    .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_vaddr(req_vaddr), .req_wdata(req_wdata),
    .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_paddr(mem_req_paddr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit timed_out = 1'b0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) timed_out <= 1'b1;
  end

  // bench memory and reference cache state
  logic [31:0] bmem [logic [31:0]];
  bit          mv [1024];
  logic [19:0] mt [1024];

  int          obs_nrd, obs_nwr, obs_lat;
  logic [31:0] obs_rpa, obs_wpa, obs_wdat, obs_rd;
  bit          obs_stall_bad, obs_busy_bad, obs_hold_bad, obs_hung;

  function automatic logic [31:0] memval(input logic [31:0] wa);
    if (bmem.exists(wa)) return bmem[wa];
    return (wa * 32'h9E37_79B1) ^ 32'h1234_5678;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 1024; i++) mv[i] = 1'b0;
  endtask

  task automatic access(input bit wr, input logic [31:0] va, input logic [31:0] wd,
                        input logic [19:0] ppn, input int stall, input int mdly,
                        input int rdly);
    int cyc = 0;
    int mwait = 0;
    int rwait = 0;
    int pend = 0;
    bit rd_pend = 1'b0;
    bit done = 1'b0;
    logic [31:0] pend_pa = '0;
    logic [31:0] held_pa = '0;
    obs_nrd = 0; obs_nwr = 0; obs_lat = -1;
    obs_stall_bad = 0; obs_busy_bad = 0; obs_hold_bad = 0; obs_hung = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_vaddr = va; req_wdata = wd;
    tlb_ppn = ppn; tlb_hit = (stall == 0);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) begin
      mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; rsp_ready = 1'b0;
      if (req_ready) obs_busy_bad = 1'b1;
      if (cyc >= stall) tlb_hit = 1'b1;
      else if (mem_req_valid || rsp_valid) obs_stall_bad = 1'b1;
      if (rd_pend) begin
        if (pend == 0) begin
          mem_rsp_valid = 1'b1; mem_rsp_rdata = memval(pend_pa); rd_pend = 1'b0;
        end else pend--;
      end else if (mem_req_valid) begin
        if (mwait == 0) held_pa = mem_req_paddr;
        else if (mem_req_paddr != held_pa) obs_hold_bad = 1'b1;
        if (mwait == mdly) begin
          mem_req_ready = 1'b1; mwait = 0;
          if (mem_req_write) begin
            obs_nwr++; obs_wpa = mem_req_paddr; obs_wdat = mem_req_wdata;
          end else begin
            obs_nrd++; obs_rpa = mem_req_paddr;
            rd_pend = 1'b1; pend = 1; pend_pa = mem_req_paddr;
          end
        end else mwait++;
      end
      if (rsp_valid) begin
        if (obs_lat < 0) begin obs_lat = cyc; obs_rd = rsp_rdata; end
        else if (rsp_rdata != obs_rd) obs_hold_bad = 1'b1;
        if (rwait == rdly) begin rsp_ready = 1'b1; done = 1'b1; end
        else rwait++;
      end
      @(negedge clk);
      cyc++;
      if (cyc > 300 || timed_out) begin obs_hung = 1'b1; done = 1'b1; end
    end
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; rsp_ready = 1'b0;
    chk(!obs_hung, "R9", "access completed", 32'(cyc), 32'd300);
    chk(!obs_busy_bad && !obs_hold_bad, "R9", "ready low and payload held while busy",
        {30'd0, obs_busy_bad, obs_hold_bad}, 32'd0);
    if (stall > 0)
      chk(!obs_stall_bad, "R8", "no activity during TLB miss", 32'(obs_stall_bad), 32'd0);
  endtask

  task automatic do_load(input logic [31:0] va, input logic [19:0] ppn, input int stall,
                         input int mdly, input int rdly, input string req);
    logic [9:0]  idx = va[11:2];
    logic [31:0] wa  = {ppn, va[11:2], 2'b00};
    bit miss = !(mv[idx] && mt[idx] == ppn);
    access(1'b0, va, 32'd0, ppn, stall, mdly, rdly);
    chk(obs_rd == memval(wa), req, "load data", obs_rd, memval(wa));
    chk(obs_nrd == (miss ? 1 : 0), miss ? "R6" : "R4", "fetch count",
        32'(obs_nrd), miss ? 32'd1 : 32'd0);
    chk(obs_nwr == 0, "R4", "no write on load", 32'(obs_nwr), 32'd0);
    if (miss) chk(obs_rpa == wa, "R5", "fetch address", obs_rpa, wa);
    else chk(obs_lat == 1 + stall, "R4", "hit latency", 32'(obs_lat), 32'(1 + stall));
    mv[idx] = 1'b1; mt[idx] = ppn;
  endtask

  task automatic do_store(input logic [31:0] va, input logic [31:0] wd, input logic [19:0] ppn,
                          input int stall, input int mdly, input int rdly);
    logic [31:0] pa = {ppn, va[11:0]};
    access(1'b1, va, wd, ppn, stall, mdly, rdly);
    chk(obs_nwr == 1 && obs_nrd == 0, "R7", "one write, no fetch",
        32'(obs_nwr * 16 + obs_nrd), 32'd16);
    chk(obs_wpa == pa, "R7", "write address", obs_wpa, pa);
    chk(obs_wdat == wd, "R7", "write data", obs_wdat, wd);
    bmem[{pa[31:2], 2'b00}] = wd;
  endtask

  initial begin
    void'($urandom(32'd20240917));
    clear_model();
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1", "reset outputs",
        {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);

    do_load(32'h0000_1008, 20'h00010, 0, 0, 0, "R5");        // cold miss
    do_load(32'h0000_1008, 20'h00010, 0, 0, 0, "R4");        // hit
    do_load(32'h7777_7008, 20'h00010, 0, 0, 0, "R2");        // alias, same line
    do_load(32'h0000_1008, 20'h00020, 0, 0, 0, "R3");        // other page, same set
    do_load(32'h0000_1008, 20'h00010, 0, 1, 0, "R3");        // evicted again
    do_store(32'h0000_100A, 32'hDEAD_BEEF, 20'h00010, 0, 0, 0);
    do_load(32'h0000_1008, 20'h00010, 0, 0, 0, "R7");        // hit with new word
    chk(obs_nrd == 0 && obs_rd == 32'hDEAD_BEEF, "R7", "store hit updated line",
        obs_rd, 32'hDEAD_BEEF);
    do_store(32'h0000_2010, 32'h0BAD_F00D, 20'h00033, 0, 0, 0); // store miss
    do_load(32'h0000_2010, 20'h00033, 0, 0, 0, "R7");
    chk(obs_nrd == 1, "R7", "store miss did not allocate", 32'(obs_nrd), 32'd1);
    do_load(32'h0000_2010, 20'h00033, 0, 0, 0, "R6");        // replayed fill now resident
    do_load(32'h0000_3FFC, 20'h00044, 4, 0, 0, "R8");        // stalled miss
    do_load(32'h0000_3FFC, 20'h00044, 3, 0, 0, "R8");        // stalled hit
    do_load(32'h0000_3000, 20'h00045, 0, 3, 3, "R9");        // back-pressure
    do_store(32'h0000_3000, 32'h1357_9BDF, 20'h00045, 2, 4, 2);

    @(negedge clk); flush_all = 1'b1;
    @(negedge clk); flush_all = 1'b0;
    clear_model();
    do_load(32'h0000_1008, 20'h00010, 0, 0, 0, "R1");
    chk(obs_nrd == 1, "R1", "flush forced a miss", 32'(obs_nrd), 32'd1);

    for (int n = 0; n < 300 && !timed_out; n++) begin
      logic [31:0] va;
      logic [9:0]  ix;
      logic [19:0] pp;
      ix = ($urandom % 2) ? 10'(($urandom % 4) + 1020) : 10'($urandom % 8);
      va = {$urandom, 12'h000};
      va[11:0] = {ix, 2'($urandom)};
      pp = 20'($urandom % 4);
      if ($urandom % 3 == 0)
        do_store(va, $urandom, pp, $urandom % 3, $urandom % 3, $urandom % 2);
      else
        do_load(va, pp, $urandom % 3, $urandom % 3, $urandom % 2, "R2");
    end

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    clear_model();
    do_load(32'h0000_3000, 20'h00045, 0, 0, 0, "R1");
    chk(obs_nrd == 1, "R1", "reset forced a miss", 32'(obs_nrd), 32'd1);

    chk(!timed_out, "R9", "watchdog", 32'(cycles), 32'd150000);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule